// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading translation tables held in memory. A request carries one 64-bit virtual address. The walker picks a root table from the top address bit and descends through up to four directory levels, highest first. It then either reads a final leaf entry or stops early on a large-page directory entry. One pulse reports the outcome: a page-aligned physical address with a write-permission flag and a global flag, or a no-match indication.

Each directory level and the leaf level has its own configured shift and width. The shift says where that level's index field starts in the virtual address, and the width says how many bits the field has. A level with zero width is left out of the walk. The walker has one 64-bit read port to memory, holds one walk at a time, and waits as long as memory takes to answer each read.

Top module: `ptw_walker`

## Requirements
- R1: Virtual address bit 63 selects the root table: 1 selects `cfg_root_hi` and 0 selects `cfg_root_lo`. The selected root is cut to its low `PA_W` bits (48 by default).
- R2: Directory levels are visited in the order 4, 3, 2, 1. A level whose width field is zero issues no memory read.
- R3: The read address at a level is `table | (((va >> shift) & ((1 << width) - 1)) << 3)`, where `table` is the current table base.
- R4: A directory entry that is not a large page is cut to its low `PA_W` bits and becomes the table base for the next read.
- R5: A directory entry with bit 6 set (large page) ends the walk with no further read. Bit 6 and bits 14:13 are cleared. If bit 12 is set, bit 12 is cleared and bit 7 (global) is set.
- R6: When no large page is found, exactly one more read is made with the leaf-level shift and width, and the data it returns is the final entry. This data is not cut to `PA_W`.
- R7: A final entry with bit 0 (valid) clear gives `miss`=1, with `pa`, `writable` and `global_pg` all zero.
- R8: For a valid final entry, `writable` equals bit 1 (dirty) and `global_pg` equals bit 7.
- R9: For a valid final entry, `pa` is computed in three steps:
  - add the entry to the virtual-address bits (cut to `PA_W`) below the shift of the last level used;
  - clear bits 63, 62 and 61;
  - clear bits below `PAGE_SHIFT` (12).
- R10: Only one walk is in flight. `req_valid` is ignored while `busy` is high and does not change the result of the walk in progress.
- R11: `mem_req` stays high with `mem_addr` stable until `mem_rvalid` is seen. Any number of wait cycles is allowed.
- R12: `done` is a one-cycle pulse in the cycle after the last read is accepted. `busy` is already low in that cycle, so a request presented then is accepted.
- R13: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_root_lo | input | 64 | Root table for addresses with bit 63 clear |
| cfg_root_hi | input | 64 | Root table for addresses with bit 63 set |
| cfg_shift | input | 5x6 | Index start bit per level; element 0 is the leaf level |
| cfg_width | input | 5x5 | Index width per level; element 0 is the leaf level |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_va | input | 64 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| miss | output | 1 | No valid mapping |
| pa | output | 64 | Page-aligned physical address |
| writable | output | 1 | Mapping allows writes |
| global_pg | output | 1 | Mapping is global |

## Verification
Two functions can land in the same cycle: the completion pulse of one walk and the acceptance of the next request. The bench provokes this by raising `req_valid` at the exact cycle it sees `done`. It then checks that `busy` was already low and that the second result matches its own vector. A second overlap also gets its own test: a request is held high throughout a walk in flight, and the bench checks that only the first walk's result arrives and no further `done` follows.

// File: rtl/ptw_pkg.sv
// Shared constants for the page table walker.
// Entry bit positions are fixed by the table format that software builds;
// they must match the layout the requirements describe.
package ptw_pkg;
    localparam int VA_W     = 64;
    localparam int SHIFT_W  = 6;
    localparam int WIDTH_W  = 5;

    localparam int B_VALID  = 0;
    localparam int B_DIRTY  = 1;
    localparam int B_HUGE   = 6;
    localparam int B_GLOB   = 7;
    localparam int B_HGLOB  = 12;
    localparam int B_LVL_LO = 13;
    localparam int B_LVL_HI = 14;
    localparam int B_NORD   = 61;
    localparam int B_NOEX   = 62;
    localparam int B_RPL    = 63;

    typedef enum logic {ST_IDLE, ST_FETCH} walk_state_t;
endpackage

// File: rtl/ptw_lvl_pick.sv
// Chooses the next directory level to visit: the highest level at or below
// from_lvl whose width is non-zero. Returns 0 (leaf level) when none is left.
// Assumes from_lvl never exceeds LEVELS.
module ptw_lvl_pick import ptw_pkg::*; #(
    parameter int LEVELS = 4,
    localparam int LW    = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS:1][WIDTH_W-1:0] widths,
    input  logic [LW-1:0]                from_lvl,
    output logic [LW-1:0]                next_lvl
);
    logic [LEVELS:1] active;

    // One enable per level: a level takes part when its width is non-zero.
    for (genvar g = 1; g <= LEVELS; g++) begin : g_active
        assign active[g] = |widths[g];
    end

    // Ascending scan; the last hit wins, which gives the highest level.
    always_comb begin
        next_lvl = '0;
        for (int k = 1; k <= LEVELS; k++) begin
            if (active[k] && (LW'(k) <= from_lvl)) begin
                next_lvl = LW'(k);
            end
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
// Forms the read address for one table level from the current table base
// and the index field of the virtual address. Pure combinational.
module ptw_addr_gen import ptw_pkg::*; (
    input  logic [VA_W-1:0]    va,
    input  logic [VA_W-1:0]    table_base,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [WIDTH_W-1:0] width,
    output logic [VA_W-1:0]    entry_addr
);
    logic [VA_W-1:0] idx;

    // Extract the index field, then scale it to an 8-byte entry slot.
    always_comb begin
        idx        = (va >> shift) & ((64'd1 << width) - 64'd1);
        entry_addr = table_base | (idx << 3);
    end
endmodule

// File: rtl/ptw_pte_shape.sv
// Turns the entry that ends a walk into the result fields. A large-page
// directory entry is first rewritten into leaf form. Assumes the caller has
// already cut directory entries to the physical width.
module ptw_pte_shape import ptw_pkg::*; #(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    localparam logic [VA_W-1:0] PA_MASK   = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}},
    localparam logic [VA_W-1:0] PAGE_MASK = ~((64'd1 << PAGE_SHIFT) - 64'd1)
) (
    input  logic [VA_W-1:0]    raw,
    input  logic               is_huge,
    input  logic [VA_W-1:0]    va,
    input  logic [SHIFT_W-1:0] last_shift,
    output logic [VA_W-1:0]    pa,
    output logic               writable,
    output logic               global_pg,
    output logic               miss
);
    logic [VA_W-1:0] leaf;
    logic [VA_W-1:0] sum;

    // Rewrite a large-page entry: drop size/level marks, move the global flag.
    always_comb begin
        leaf = raw;
        if (is_huge) begin
            leaf[B_HUGE]            = 1'b0;
            leaf[B_LVL_HI:B_LVL_LO] = '0;
            if (raw[B_HGLOB]) begin
                leaf[B_HGLOB] = 1'b0;
                leaf[B_GLOB]  = 1'b1;
            end
        end
    end

    // Add the in-page offset, strip access-control bits, align to a page.
    always_comb begin
        sum = leaf + ((va & PA_MASK) & ((64'd1 << last_shift) - 64'd1));
        sum[B_RPL]  = 1'b0;
        sum[B_NOEX] = 1'b0;
        sum[B_NORD] = 1'b0;
        miss      = ~leaf[B_VALID];
        pa        = miss ? '0 : (sum & PAGE_MASK);
        writable  = ~miss & leaf[B_DIRTY];
        global_pg = ~miss & leaf[B_GLOB];
    end
endmodule

// File: rtl/ptw_walker.sv
// Sequential page table walker. Accepts one virtual address and reads
// directory levels LEVELS..1 (skipping zero-width ones), then the leaf level
// unless a large-page entry ends the walk first. It reports the result with
// a one-cycle done pulse. Assumes memory answers each held request exactly
// once, with mem_rvalid high only while mem_req is high.
module ptw_walker import ptw_pkg::*; #(
    parameter int LEVELS     = 4,
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    localparam int LW        = $clog2(LEVELS + 1),
    localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [VA_W-1:0]               cfg_root_lo,
    input  logic [VA_W-1:0]               cfg_root_hi,
    input  logic [LEVELS:0][SHIFT_W-1:0]  cfg_shift,
    input  logic [LEVELS:0][WIDTH_W-1:0]  cfg_width,
    input  logic                          req_valid,
    input  logic [VA_W-1:0]               req_va,
    output logic                          busy,
    output logic                          mem_req,
    output logic [VA_W-1:0]               mem_addr,
    input  logic                          mem_rvalid,
    input  logic [VA_W-1:0]               mem_rdata,
    output logic                          done,
    output logic                          miss,
    output logic [VA_W-1:0]               pa,
    output logic                          writable,
    output logic                          global_pg
);
    walk_state_t     state_q;
    logic [VA_W-1:0] va_q;
    logic [VA_W-1:0] table_q;
    logic [LW-1:0]   lvl_q;

    logic [LW-1:0]   pick_from;
    logic [LW-1:0]   pick_next;
    logic [VA_W-1:0] root_sel;
    logic [VA_W-1:0] rd_cut;
    logic            at_dir;
    logic            huge_hit;
    logic            finish;
    logic [VA_W-1:0] shape_raw;
    logic [VA_W-1:0] res_pa;
    logic            res_wr;
    logic            res_glob;
    logic            res_miss;

    // Level cursor search starts from the top on a new walk, else below current.
    assign pick_from = (state_q == ST_IDLE) ? LW'(LEVELS) : (lvl_q - LW'(1));

    ptw_lvl_pick #(.LEVELS(LEVELS)) u_pick (
        .widths   (cfg_width[LEVELS:1]),
        .from_lvl (pick_from),
        .next_lvl (pick_next)
    );

    ptw_addr_gen u_addr (
        .va         (va_q),
        .table_base (table_q),
        .shift      (cfg_shift[lvl_q]),
        .width      (cfg_width[lvl_q]),
        .entry_addr (mem_addr)
    );

    // Decode the returned entry: directory cut, large-page stop, walk end.
    always_comb begin
        root_sel  = (req_va[VA_W-1] ? cfg_root_hi : cfg_root_lo) & PA_MASK;
        rd_cut    = mem_rdata & PA_MASK;
        at_dir    = (lvl_q != '0);
        huge_hit  = at_dir & rd_cut[B_HUGE];
        finish    = (state_q == ST_FETCH) & mem_rvalid & (~at_dir | huge_hit);
        shape_raw = at_dir ? rd_cut : mem_rdata;
    end

    ptw_pte_shape #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_shape (
        .raw        (shape_raw),
        .is_huge    (at_dir),
        .va         (va_q),
        .last_shift (cfg_shift[lvl_q]),
        .pa         (res_pa),
        .writable   (res_wr),
        .global_pg  (res_glob),
        .miss       (res_miss)
    );

    // Walk sequencer: accept, step through levels, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            table_q   <= '0;
            lvl_q     <= '0;
            done      <= 1'b0;
            miss      <= 1'b0;
            pa        <= '0;
            writable  <= 1'b0;
            global_pg <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        table_q <= root_sel;
                        lvl_q   <= pick_next;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (finish) begin
                        state_q   <= ST_IDLE;
                        done      <= 1'b1;
                        miss      <= res_miss;
                        pa        <= res_pa;
                        writable  <= res_wr;
                        global_pg <= res_glob;
                    end else if (mem_rvalid) begin
                        table_q <= rd_cut;
                        lvl_q   <= pick_next;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign mem_req = (state_q == ST_FETCH);

    // An unanswered read keeps its request and address.
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A walk only starts from a presented request.
    assert_start_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // A hit is page aligned with the access-control bits stripped.
    assert_pa_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !miss) |-> ((pa[PAGE_SHIFT-1:0] == '0) && (pa[63:61] == 3'b000)));

    // A miss carries no address or permission.
    assert_miss_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && miss) |-> ((pa == '0) && !writable && !global_pg));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] va;
        logic [63:0] exp_pa;
        logic [63:0] exp_first;
        logic        exp_miss;
        logic        exp_wr;
        logic        exp_glob;
        logic [7:0]  exp_nrd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{64'h0000_0080_8060_4ABC, 64'h0ABC_D000, 64'h1008, 1'b0, 1'b1, 1'b0, 8'd4},
        '{64'h0000_0080_8060_5010, 64'h0123_4000, 64'h1008, 1'b0, 1'b0, 1'b0, 8'd4},
        '{64'h0000_0080_8060_6000, 64'h0,         64'h1008, 1'b1, 1'b0, 1'b0, 8'd4},
        '{64'h8000_0000_0000_0123, 64'h0999_9000, 64'h2000, 1'b0, 1'b1, 1'b0, 8'd4},
        '{64'h0000_0080_80E1_2345, 64'h4001_2000, 64'h1008, 1'b0, 1'b1, 1'b1, 8'd3},
        '{64'h0000_0082_4345_6789, 64'h8345_6000, 64'h1008, 1'b0, 1'b0, 1'b0, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] root_lo, root_hi;
    logic [4:0][5:0] cfg_s;
    logic [4:0][4:0] cfg_w;
    logic req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic busy, mem_req, done, miss, writable, global_pg;
    logic [63:0] mem_addr, pa;
    logic mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem_img [logic [63:0]];
    logic [63:0] rd_addr [8];
    int nrd = 0;
    int lat = 0;
    int wait_cnt = 0;
    int total = 0;
    int bad = 0;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .cfg_root_lo(root_lo), .cfg_root_hi(root_hi),
        .cfg_shift(cfg_s), .cfg_width(cfg_w), .req_valid(req_valid), .req_va(req_va),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .miss(miss), .pa(pa),
        .writable(writable), .global_pg(global_pg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory responder: answers a held request after lat idle cycles.
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (wait_cnt < lat) begin
                wait_cnt <= wait_cnt + 1;
            end else begin
                wait_cnt   <= 0;
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
                if (nrd < 8) rd_addr[nrd] <= mem_addr;
                nrd <= nrd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [63:0] va);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done, "R12 walk completion", 64'(done), 64'd1);
    endtask

    task automatic cfg_a();
        root_lo = 64'h1000;
        root_hi = 64'hFFFF_0000_0000_2000;
        cfg_s = '{6'd39, 6'd30, 6'd21, 6'd0, 6'd12};
        cfg_w = '{5'd9, 5'd9, 5'd9, 5'd0, 5'd9};
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        nrd = 0;
        start(v.va);
        wait_done();
        check(miss == v.exp_miss, {tag, " R7 miss"}, 64'(miss), 64'(v.exp_miss));
        check(writable == v.exp_wr, {tag, " R8 writable"}, 64'(writable), 64'(v.exp_wr));
        check(global_pg == v.exp_glob, {tag, " R5 R8 global"}, 64'(global_pg), 64'(v.exp_glob));
        check(pa == v.exp_pa, {tag, " R9 pa"}, pa, v.exp_pa);
        check(nrd == int'(v.exp_nrd), {tag, " R2 R6 read count"}, 64'(nrd), 64'(v.exp_nrd));
        check(rd_addr[0] == v.exp_first, {tag, " R1 R3 first address"}, rd_addr[0], v.exp_first);
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int extra;
        cfg_a();
        mem_img[64'h1008] = 64'hFFFF_0000_0000_3000;
        mem_img[64'h3010] = 64'h4000;
        mem_img[64'h4018] = 64'h5000;
        mem_img[64'h5020] = 64'hE000_0000_0ABC_D003;
        mem_img[64'h5028] = 64'h0123_4001;
        mem_img[64'h5030] = 64'h0777_7002;
        mem_img[64'h2000] = 64'h6000;
        mem_img[64'h6000] = 64'h7000;
        mem_img[64'h7000] = 64'h8000;
        mem_img[64'h8000] = 64'h0999_9003;
        mem_img[64'h4038] = 64'h4000_7043;
        mem_img[64'h3048] = 64'h8000_0041;
        mem_img[64'h1018] = 64'h9000;
        mem_img[64'h9020] = 64'h0555_5003;
        mem_img[64'h1000] = 64'h0666_6083;

        // R13: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R13 reset outputs", {61'd0, busy, done, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R13 after release", {61'd0, busy, done, mem_req}, 64'd0);

        // Vector table under configuration A
        foreach (VEC[i]) run_vec(VEC[i], $sformatf("vec%0d", i));

        // R4: upper junk of a directory entry is cut before reuse
        nrd = 0;
        start(VEC[0].va);
        wait_done();
        check(rd_addr[1] == 64'h3010, "R4 second address", rd_addr[1], 64'h3010);

        // R2: only level 2 active among directories
        cfg_w = '{5'd0, 5'd0, 5'd9, 5'd0, 5'd9};
        nrd = 0;
        start(64'h0060_4005);
        wait_done();
        check(nrd == 2, "R2 skipped levels read count", 64'(nrd), 64'd2);
        check(rd_addr[0] == 64'h1018, "R2 R3 level 2 address", rd_addr[0], 64'h1018);
        check(pa == 64'h0555_5000, "R9 skip-path pa", pa, 64'h0555_5000);

        // R6: every width zero, a single leaf read at the root
        cfg_w = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
        nrd = 0;
        start(64'h0F00);
        wait_done();
        check(nrd == 1 && rd_addr[0] == 64'h1000, "R6 leaf-only read", rd_addr[0], 64'h1000);
        check(pa == 64'h0666_6000 && global_pg && writable, "R8 leaf-only result", pa, 64'h0666_6000);

        // R11: slow memory gives identical results
        cfg_a();
        lat = 3;
        run_vec(VEC[4], "slow huge R11");
        run_vec(VEC[0], "slow leaf R11");

        // R10: requests while busy are ignored
        nrd = 0;
        start(VEC[1].va);
        req_valid = 1'b1;
        req_va    = VEC[2].va;
        repeat (3) @(negedge clk);
        check(busy, "R10 busy during walk", 64'(busy), 64'd1);
        wait_done();
        req_valid = 1'b0;
        check(pa == VEC[1].exp_pa && !miss, "R10 first walk result kept", pa, VEC[1].exp_pa);
        extra = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R10 no walk from ignored request", 64'(extra), 64'd0);

        // R12: new request presented in the done cycle
        lat = 0;
        start(VEC[3].va);
        wait_done();
        check(!busy, "R12 idle in done cycle", 64'(busy), 64'd0);
        check(pa == VEC[3].exp_pa, "R1 first of pair", pa, VEC[3].exp_pa);
        start(VEC[5].va);
        check(busy, "R12 back-to-back accepted", 64'(busy), 64'd1);
        wait_done();
        check(pa == VEC[5].exp_pa && !writable, "R12 R5 second of pair", pa, VEC[5].exp_pa);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule